// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit picks one of two operands under control of a 4-bit condition code that is tested against the four arithmetic flags (negative, zero, carry, overflow). If the condition holds, the result is operand A. If it does not, the result is operand B: passed through unchanged, plus one, bitwise inverted, or two's-complement negated, as the operation select chooses. With both operands tied to zero and the condition inverted, the increment form gives a boolean 0/1 and the invert form gives a 0/all-ones mask. The unit works at 64-bit width or at 32-bit width.

A request is taken on a cycle where `in_valid` is high. The result is registered and comes out one clock later, with `out_valid`. This lets a pipeline compute both arms of an if-then-else and keep one of them without a branch.

Top module: `csel_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 in the cycle after a cycle where `in_valid` was sampled high, and 0 after a cycle where it was sampled low.
- R3: When the condition holds, `result` is operand A whatever `op_sel` is.
- R4: When the condition fails and `op_sel` is 2'b00, `result` is operand B.
- R5: When the condition fails and `op_sel` is 2'b01, `result` is B plus one, wrapping to zero at the width limit.
- R6: When the condition fails and `op_sel` is 2'b10, `result` is the bitwise inverse of B.
- R7: When the condition fails and `op_sel` is 2'b11, `result` is the two's-complement negation of B.
- R8: With flags packed as {N,Z,C,V} in `flags[3:0]`, codes 0000..0111 hold when, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R9: Code 1000 holds when C=1 and Z=0; 1001 when C=0 or Z=1; 1010 when N equals V; 1011 when N differs from V; 1100 when Z=0 and N equals V; 1101 when Z=1 or N differs from V.
- R10: Codes 1110 and 1111 hold for every flag value.
- R11: With `wide` at 0 (32-bit mode) the upper half of `result` is zero and increment and negate wrap modulo 2^32; with `wide` at 1 the full 64 bits are used.
- R12: With A and B both zero, increment with a failing condition gives 1 and invert with a failing condition gives all ones, while a holding condition gives 0 in both cases.
- R13: On a cycle where `in_valid` is low, `result` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | Operand taken when the condition holds |
| op_b | input | 64 | Operand modified when the condition fails |
| cond | input | 4 | Condition code |
| flags | input | 4 | Flags {N,Z,C,V} |
| op_sel | input | 2 | 00 pass, 01 increment, 10 invert, 11 negate |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after its request is sampled. The bench drives inputs on the falling edge and puts the predicted value into a queue at the same moment. A monitor reads `out_valid` and `result` on each later falling edge, half a cycle after the register updates, and compares them with the head of the queue. An output with no queued item fails, and so does an item still left in the queue at the end. The hold behaviour is checked by looking at `result` after several idle cycles in which the inputs are changed.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_INC  = 2'b01,
    OP_INV  = 2'b10,
    OP_NEG  = 2'b11
  } csel_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  // Condition evaluation against {N,Z,C,V}
  function automatic logic cond_holds(input logic [3:0] code, input logic [3:0] nzcv);
    logic n, z, c, v;
    n = nzcv[FLG_N];
    z = nzcv[FLG_Z];
    c = nzcv[FLG_C];
    v = nzcv[FLG_V];
    case (code)
      4'b0000: cond_holds = z;
      4'b0001: cond_holds = !z;
      4'b0010: cond_holds = c;
      4'b0011: cond_holds = !c;
      4'b0100: cond_holds = n;
      4'b0101: cond_holds = !n;
      4'b0110: cond_holds = v;
      4'b0111: cond_holds = !v;
      4'b1000: cond_holds = c && !z;
      4'b1001: cond_holds = !c || z;
      4'b1010: cond_holds = (n == v);
      4'b1011: cond_holds = (n != v);
      4'b1100: cond_holds = !z && (n == v);
      4'b1101: cond_holds = z || (n != v);
      default: cond_holds = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       pass
);
  always_comb pass = cond_holds(code, nzcv);
endmodule

// File: rtl/csel_alt_gen.sv
module csel_alt_gen
  import csel_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [1:0]   op,
  output logic [W-1:0] alt
);
  function automatic logic [W-1:0] modify(input logic [W-1:0] x, input logic [1:0] sel);
    case (csel_op_e'(sel))
      OP_INC:  modify = x + W'(1);
      OP_INV:  modify = ~x;
      OP_NEG:  modify = ~x + W'(1);
      default: modify = x;
    endcase
  endfunction

  always_comb alt = modify(src, op);
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags,
  input  logic [1:0]        op_sel,
  input  logic              wide,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  logic              cond_ok;
  logic [DATA_W-1:0] alt_b;
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] next_result;

  csel_cond_eval u_cond (
    .code (cond),
    .nzcv (flags),
    .pass (cond_ok)
  );

  csel_alt_gen #(.W(DATA_W)) u_alt (
    .src (op_b),
    .op  (op_sel),
    .alt (alt_b)
  );

  always_comb begin
    size_mask   = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    picked      = cond_ok ? op_a : alt_b;
    next_result = picked & size_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [3:0]        cond,
  input logic [1:0]        op_sel,
  input logic              wide,
  input logic              cond_ok,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_take_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_ok && wide) |=> (result == $past(op_a)));

  p_pass_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cond_ok && wide && op_sel == 2'b00) |=> (result == $past(op_b)));

  p_always_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[3:1] == 3'b111) |-> cond_ok);

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(result));
endmodule

bind csel_unit csel_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .cond      (cond),
  .op_sel    (op_sel),
  .wide      (wide),
  .cond_ok   (cond_ok),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/csel_unit_bench.sv
module csel_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  typedef struct {
    logic [W-1:0] value;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   cond = '0;
  logic [3:0]   flags = '0;
  logic [1:0]   op_sel = '0;
  logic         wide = 1'b1;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [W-1:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_unit u_csel_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cond(cond), .flags(flags), .op_sel(op_sel), .wide(wide),
    .out_valid(out_valid), .result(result)
  );

  // Model: base test on code[3:1], code[0] inverts it except for 111
  function automatic bit model_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v, base;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: return 1'b1;
    endcase
    return c[0] ? !base : base;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [3:0] c, input logic [3:0] f, input logic [1:0] op, input bit wd);
    logic [W-1:0] r;
    longint unsigned bu;
    bu = wd ? b : {32'd0, b[31:0]};
    if (model_cond(c, f)) r = a;
    else case (op)
      2'b00: r = bu;
      2'b01: r = bu + 1;
      2'b10: r = ~bu;
      default: r = 0 - bu;
    endcase
    if (!wd) r = {32'd0, r[31:0]};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c,
      input logic [3:0] f, input logic [1:0] op, input bit wd, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; cond = c; flags = f; op_sel = op; wide = wd;
    e.value = model(a, b, c, f, op, wd);
    e.tag = tag;
    last_exp = e.value;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
      cond = 4'($urandom); op_sel = 2'($urandom); wide = 1'($urandom);
    end
  endtask

  // Monitor: outputs settle at the rising edge, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", result, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result === e.value, e.tag, result, e.value);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", {63'd0, out_valid}, '0);
    check(result === '0, "R1 result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", {63'd0, out_valid}, '0);
    check(result === '0, "R1 result after reset", result, '0);

    // R8 R9 R10: every code against every flag pattern, increment form
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive(64'hAAAA_0000_0000_0001, 64'h0000_0000_0000_0100, 4'(c), 4'(f), 2'b01, 1'b1,
              c < 8 ? "R8 single-flag code" : (c < 14 ? "R9 compound code" : "R10 always code"));

    // R3: condition holds, all ops
    for (int op = 0; op < 4; op++)
      drive(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 4'b0000, 4'b0100, 2'(op), 1'b1, "R3 take A");

    // R4..R7: condition fails (EQ with Z=0)
    drive(64'h1, 64'hDEAD_BEEF_CAFE_F00D, 4'b0000, 4'b0000, 2'b00, 1'b1, "R4 pass B");
    drive(64'h1, 64'h0000_0000_0000_0041, 4'b0000, 4'b0000, 2'b01, 1'b1, "R5 increment");
    drive(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000, 4'b0000, 2'b01, 1'b1, "R5 increment wrap");
    drive(64'h1, 64'h00FF_00FF_1234_0000, 4'b0000, 4'b0000, 2'b10, 1'b1, "R6 invert");
    drive(64'h1, 64'h0000_0000_0000_0005, 4'b0000, 4'b0000, 2'b11, 1'b1, "R7 negate");
    drive(64'h1, 64'h8000_0000_0000_0000, 4'b0000, 4'b0000, 2'b11, 1'b1, "R7 negate min");
    drive(64'h1, 64'h0, 4'b0000, 4'b0000, 2'b11, 1'b1, "R7 negate zero");

    // R11: 32-bit mode
    drive(64'hFFFF_FFFF_0000_0007, 64'h1, 4'b1110, 4'b0000, 2'b00, 1'b0, "R11 A truncated");
    drive(64'h1, 64'h5555_5555_FFFF_FFFF, 4'b0001, 4'b0100, 2'b01, 1'b0, "R11 increment wraps 2^32");
    drive(64'h1, 64'h7777_7777_0000_0003, 4'b0001, 4'b0100, 2'b11, 1'b0, "R11 negate 32");
    drive(64'h1, 64'h0000_0000_F0F0_F0F0, 4'b0001, 4'b0100, 2'b10, 1'b0, "R11 invert 32");

    // R12: set / set-mask with zero operands, inverted condition (EQ -> NE)
    drive(64'h0, 64'h0, 4'b0001, 4'b0100, 2'b01, 1'b1, "R12 set gives 1");
    drive(64'h0, 64'h0, 4'b0001, 4'b0000, 2'b01, 1'b1, "R12 set gives 0");
    drive(64'h0, 64'h0, 4'b0001, 4'b0100, 2'b10, 1'b1, "R12 mask gives ones");
    drive(64'h0, 64'h0, 4'b0001, 4'b0000, 2'b10, 1'b1, "R12 mask gives 0");
    drive(64'h0, 64'h0, 4'b0001, 4'b0100, 2'b10, 1'b0, "R12 mask 32-bit");

    // R13: hold while idle
    drive(64'h0BAD_F00D_0000_1111, 64'h2, 4'b1111, 4'b0000, 2'b11, 1'b1, "R3 before hold");
    idle(4);
    check(result === last_exp, "R13 hold while idle", result, last_exp);
    check(out_valid === 1'b0, "R2 out_valid low when idle", {63'd0, out_valid}, '0);
    check(sb.size() == 0, "R2 every request answered", W'(sb.size()), '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule